// File: doc/BRIEF.md
# Control-Bit Clock-Domain Crossing Bridge

This block moves three audio-link control bits from a fast register clock into a much slower serial bit clock. The three bits are replay disable, record disable and serial format select. Software writes a 32-bit control word in the fast domain with a one-cycle strobe. The bridge extracts the three crossing bits and hands them across with a toggle request/acknowledge handshake. The slow domain then drives registered, glitch-free copies of the controls.

A single transfer takes a few cycles of each clock. Software may write again while a transfer is still in flight. Such writes go into a holding register, and the newest held value is launched as soon as the acknowledge comes back. Intermediate values can be skipped, but the last value written always reaches the slow side. The loopback-enable bit and all other bits of the word stay in the fast domain and never reach these outputs.

Top module: `ctl_cdc_bridge`

## Requirements
- R1: After reset, the slow outputs are all 0: replay enabled, record enabled, and I2S format selected.
- R2: Write-data bit 4 drives `slow_replay_dis`, bit 3 drives `slow_record_dis`, and bit 0 drives `slow_fmt_msb`. For the format output, 0 selects I2S and 1 selects MSB-justified.
- R3: Bit 5 (loopback enable) and bits 1, 2 and 6..31 of the write data have no effect on any slow output.
- R4: When a single write is made with no transfer in flight, the slow outputs show its value within 6 slow-clock cycles.
- R5: A written value never reaches the slow outputs before at least two slow-clock rising edges have passed. This is the synchronizer delay.
- R6: During a burst of writes faster than one transfer window, every write updates the holding register and marks it pending. Once the bridge goes idle, the slow outputs equal the last value written.
- R7: While a transfer is in flight, the launched control value and the request toggle stay stable until the acknowledge returns.
- R8: The slow outputs change only when a new request is detected in the slow domain. With no writes, they stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast register clock |
| fast_rst | input | 1 | Synchronous active-high reset, fast domain |
| cfg_wr_en | input | 1 | One-cycle write strobe for the control word |
| cfg_wr_data | input | 32 | Control word written by software |
| slow_clk | input | 1 | Serial bit clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| slow_replay_dis | output | 1 | Replay disable, slow domain |
| slow_record_dis | output | 1 | Record disable, slow domain |
| slow_fmt_msb | output | 1 | Format select, slow domain (0 I2S, 1 MSB-justified) |

## Verification
Several internal faults show at the ports only after the bridge goes idle, as a slow output that differs from the last written value:
- a holding register that drops the final write of a burst;
- a pending flag that is cleared too early;
- an acknowledge path that never releases the busy state.

Each of these shows within about ten slow-clock cycles of the last write. A wrong bit position or a leaking loopback bit shows on the first settled sample after a directed write. A synchronizer stage that is bypassed shows as an output that changes before the first slow falling edge after the write.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

    localparam int CFG_W      = 32;
    localparam int POS_REPLAY = 4;
    localparam int POS_RECORD = 3;
    localparam int POS_FMT    = 0;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_MSB = 1'b1
    } fmt_e;

    typedef struct packed {
        logic replay_dis;
        logic record_dis;
        fmt_e fmt;
    } ctl_bits_t;

    localparam int CTL_BITS = $bits(ctl_bits_t);

    localparam ctl_bits_t CTL_RESET = '{replay_dis: 1'b0, record_dis: 1'b0, fmt: FMT_I2S};

    // Keep only the fields that cross into the bit-clock domain.
    function automatic ctl_bits_t pick_ctl(input logic [CFG_W-1:0] word);
        ctl_bits_t c;
        c.replay_dis = word[POS_REPLAY];
        c.record_dis = word[POS_RECORD];
        c.fmt        = fmt_e'(word[POS_FMT]);
        return c;
    endfunction

endpackage

// File: rtl/ctl_sync_chain.sv
module ctl_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/ctl_fast_launch.sv
module ctl_fast_launch
    import ctl_xfer_pkg::*;
#(
    parameter int DATA_W      = CFG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output ctl_bits_t         launch_ctl
);
    ctl_bits_t hold_q;
    logic      pending_q;
    logic      req_q;
    logic      ack_s;
    logic      busy;
    logic      launch_go;

    ctl_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    assign busy      = (req_q != ack_s);
    assign launch_go = pending_q && !busy;

    // Holding register: the newest write always wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= CTL_RESET;
            pending_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q    <= pick_ctl(wr_data);
                pending_q <= 1'b1;
            end else if (launch_go) begin
                pending_q <= 1'b0;
            end
        end
    end

    // Launch register: held still until the acknowledge comes back.
    always_ff @(posedge clk) begin
        if (rst) begin
            launch_ctl <= CTL_RESET;
            req_q      <= 1'b0;
        end else if (launch_go) begin
            launch_ctl <= hold_q;
            req_q      <= ~req_q;
        end
    end

    assign req_tgl = req_q;

    assert_launch_stable_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(launch_ctl));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));

    assert_write_pends_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pending_q);

endmodule

// File: rtl/ctl_slow_capture.sv
module ctl_slow_capture
    import ctl_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_tgl,
    input  ctl_bits_t launch_ctl,
    output logic      ack_tgl,
    output ctl_bits_t ctl_out
);
    logic      req_s;
    logic      req_seen;
    logic      req_edge;
    logic      ack_q;
    ctl_bits_t ctl_q;

    ctl_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    assign req_edge = req_s ^ req_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen <= 1'b0;
            ack_q    <= 1'b0;
            ctl_q    <= CTL_RESET;
        end else if (req_edge) begin
            req_seen <= req_s;
            ack_q    <= req_s;
            ctl_q    <= launch_ctl;
        end
    end

    assign ack_tgl = ack_q;
    assign ctl_out = ctl_q;

    assert_out_only_on_req_R8: assert property (@(posedge clk) disable iff (rst)
        !req_edge |=> $stable(ctl_q));

    assert_ack_only_on_req_R7: assert property (@(posedge clk) disable iff (rst)
        !req_edge |=> $stable(ack_q));

endmodule

// File: rtl/ctl_cdc_bridge.sv
module ctl_cdc_bridge
    import ctl_xfer_pkg::*;
#(
    parameter int DATA_W      = CFG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              fast_clk,
    input  logic              fast_rst,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              slow_clk,
    input  logic              slow_rst,
    output logic              slow_replay_dis,
    output logic              slow_record_dis,
    output logic              slow_fmt_msb
);
    logic      req_tgl;
    logic      ack_tgl;
    ctl_bits_t launch_ctl;
    ctl_bits_t slow_ctl;

    ctl_fast_launch #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fast (
        .clk        (fast_clk),
        .rst        (fast_rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .ack_tgl    (ack_tgl),
        .req_tgl    (req_tgl),
        .launch_ctl (launch_ctl)
    );

    ctl_slow_capture #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
        .clk        (slow_clk),
        .rst        (slow_rst),
        .req_tgl    (req_tgl),
        .launch_ctl (launch_ctl),
        .ack_tgl    (ack_tgl),
        .ctl_out    (slow_ctl)
    );

    assign slow_replay_dis = slow_ctl.replay_dis;
    assign slow_record_dis = slow_ctl.record_dis;
    assign slow_fmt_msb    = slow_ctl.fmt;

    always @(posedge slow_clk) begin
        if (slow_rst) begin
            #1;
            assert_reset_zero_R1: assert ({slow_replay_dis, slow_record_dis, slow_fmt_msb} == 3'b000);
        end
    end

endmodule

// File: tb/ctl_cdc_bridge_test.sv
module ctl_cdc_bridge_test;
    localparam int FAST_PERIOD = 10;
    localparam int SLOW_PERIOD = 74;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        fast_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        fast_rst = 1'b1;
    logic        slow_rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        slow_replay_dis, slow_record_dis, slow_fmt_msb;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [31:0] last_word = '0;

    always #(FAST_PERIOD/2) fast_clk = ~fast_clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    ctl_cdc_bridge uut (
        .fast_clk        (fast_clk),
        .fast_rst        (fast_rst),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_wr_data     (cfg_wr_data),
        .slow_clk        (slow_clk),
        .slow_rst        (slow_rst),
        .slow_replay_dis (slow_replay_dis),
        .slow_record_dis (slow_record_dis),
        .slow_fmt_msb    (slow_fmt_msb)
    );

    // Expected triple {replay, record, fmt} taken from bits 4, 3, 0.
    function automatic logic [2:0] expect_of(input logic [31:0] w);
        return {w[4], w[3], w[0]};
    endfunction

    task automatic check_out(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {slow_replay_dis, slow_record_dis, slow_fmt_msb};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge fast_clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        last_word   = w;
        @(negedge fast_clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge slow_clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(FAST_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (4) @(posedge slow_clk);
        @(negedge fast_clk); fast_rst = 1'b0;
        @(negedge slow_clk); slow_rst = 1'b0;
        @(negedge slow_clk);
        check_out("R1 reset state", 3'b000);

        // R3: loopback bit and other non-crossing bits only
        write_word(32'h0000_0020);
        settle(10);
        check_out("R3 loopback bit ignored", 3'b000);
        write_word(32'hFFFF_FFE6);
        settle(10);
        check_out("R3 unrelated bits ignored", 3'b000);

        // R2: each field on its own
        write_word(32'h0000_0010); settle(10); check_out("R2 replay bit 4", 3'b100);
        write_word(32'h0000_0008); settle(10); check_out("R2 record bit 3", 3'b010);
        write_word(32'h0000_0001); settle(10); check_out("R2 format bit 0 MSB-justified", 3'b001);
        write_word(32'h0000_0000); settle(10); check_out("R2 format back to I2S", 3'b000);

        // R5 then R4: not early, but within bound
        write_word(32'h0000_0019);
        @(negedge slow_clk);
        check_out("R5 not before sync delay", 3'b000);
        settle(6);
        check_out("R4 single write latency", 3'b111);

        // R8: idle stability
        for (int i = 0; i < 12; i++) begin
            @(negedge slow_clk);
            check_out("R8 stable with no writes", 3'b111);
        end

        // R6: directed back-to-back burst, last value must arrive
        write_word(32'h0000_0001);
        write_word(32'h0000_0010);
        write_word(32'h0000_0008);
        settle(12);
        check_out("R6 burst last write wins", 3'b010);

        // R6/R3 random bursts
        for (int r = 0; r < 40; r++) begin
            int len;
            len = 1 + ($urandom % 6);
            for (int k = 0; k < len; k++) begin
                int gap;
                write_word($urandom);
                gap = $urandom % 8;
                repeat (gap) @(negedge fast_clk);
            end
            settle(12);
            check_out("R6 random burst settles to last write", expect_of(last_word));
        end

        finish_run();
    end
endmodule